// File: doc/BRIEF.md
# Sample-Clock Resynchronization Controller

This block keeps the output-rate timing of a multi-channel decimating converter lined up with events outside the chip. It watches an asynchronous active-low sync/reset line and measures each low pulse in master-clock cycles. A pulse of legal width is a request to resynchronise. A pulse that is held low for too long is a request for a device reset. A pulse of a single cycle is noise and is dropped.

The time reference of a sync request is the first falling edge of the pulse. When that edge falls on the internal output-rate tick, the timing is already right and nothing is touched. When it does not, the block waits until the pulse has proven its width. It then reloads its output-rate counter so that timing runs as if the counter had been cleared on the edge, and it strobes a filter-restart output. In chop mode every falling edge restarts the timing at once, and no alignment test is made.

Each channel has a phase offset that places its data-ready strobe inside the output period. These offsets survive any resync. Each channel also carries a settle flag. The flag stays low after a restart until the channel has produced three data-ready strobes, which is the settling time of a third-order sinc filter.

Top module: `resync_ctrl`

## Requirements
- R1: The sync line passes through two flops before use. A low pulse that lasts one master-clock cycle or less, outside chop mode, causes no filter restart and leaves the tick timing unchanged.
- R2: Outside chop mode, take a low pulse of L cycles with 2 <= L < RST_CYC whose falling edge misses the tick. If the line is first sampled low at clock edge k, the block raises a single-cycle filter restart when the pulse ends. From then on, tick is seen after edges k+2+m*OSR.
- R3: Outside chop mode, when the falling edge is processed in a cycle where tick is high, a legal-width pulse causes no filter restart, and tick keeps its earlier phase.
- R4: When the line stays low for RST_CYC cycles or more, the reset-request output pulses for one cycle on the RST_CYC-th low cycle. Outside chop mode such a pulse does not resync.
- R5: In chop mode every falling edge raises the filter restart in the cycle it is processed. This applies to glitches, aligned edges and long pulses alike. Tick is then seen after edges k+2+m*OSR.
- R6: The output-rate counter counts modulo OSR. Tick is high when it reads 0, and channel c's data-ready is high when it equals that channel's phase. A phase of 0 coincides with tick.
- R7: The phases reset to 0 and are written through ph_we, ph_sel and ph_val. A resync never alters them. A channel with a nonzero phase gives its first strobe less than one output period after the sync edge.
- R8: ch_valid[c] is 0 after reset and after every filter restart. It rises in the cycle after the third data-ready strobe of channel c that follows. A strobe in the restart cycle itself does not count.
- R9: During reset, tick and every data-ready output are high, and ch_valid, filt_rst and rst_req are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset |
| sync_n | input | 1 | Asynchronous active-low sync/reset request line |
| chop_en | input | 1 | 1 selects chop mode (restart on every falling edge) |
| ph_we | input | 1 | Phase write strobe |
| ph_sel | input | CHW | Channel selected for the phase write |
| ph_val | input | PHW | Phase value, below OSR |
| tick | output | 1 | Internal output-rate tick |
| drdy | output | NCH | Per-channel data-ready strobes |
| ch_valid | output | NCH | Per-channel settled flags |
| filt_rst | output | 1 | Single-cycle decimation/filter restart strobe |
| rst_req | output | 1 | Single-cycle device-reset request |

## Verification
On every cycle the assertions check several things. Filter restart and reset request are single-cycle strobes. Tick never repeats on the next cycle unless a restart intervenes. The settle flags drop right after a restart and rise only after a data-ready strobe. Phases hold still across a restart. The bench scenarios are needed to show the rest: that the new tick phase follows the falling edge exactly, that aligned edges, glitches and over-long pulses leave the timing alone outside chop mode, and that chop mode restarts on every edge. They also show that the per-channel strobe offsets equal the written phases before and after resyncs.

// File: rtl/resync_ctrl.sv
module resync_ctrl #(
  parameter int OSR     = 16,
  parameter int NCH     = 4,
  parameter int RST_CYC = 32,
  localparam int PHW    = $clog2(OSR),
  localparam int CHW    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sync_n,
  input  logic           chop_en,
  input  logic           ph_we,
  input  logic [CHW-1:0] ph_sel,
  input  logic [PHW-1:0] ph_val,
  output logic           tick,
  output logic [NCH-1:0] drdy,
  output logic [NCH-1:0] ch_valid,
  output logic           filt_rst,
  output logic           rst_req
);
  localparam int LW = $clog2(RST_CYC + 1);

  function automatic logic [PHW-1:0] inc(input logic [PHW-1:0] x);
    return (x == PHW'(OSR - 1)) ? '0 : x + 1'b1;
  endfunction

  logic s1, s2, s2_d;
  logic [LW-1:0] lowcnt;
  logic [PHW-1:0] dcnt, ep, ep_next;
  logic al;
  logic [NCH*PHW-1:0] ph_flat;
  logic fall, rise, width_ok, restart;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s2_d} <= 3'b111;
    else begin
      s1   <= sync_n;
      s2   <= s1;
      s2_d <= s2;
    end

  assign fall = s2_d & ~s2;
  assign rise = ~s2_d & s2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      lowcnt <= '0;
    else if (s2)                     lowcnt <= '0;
    else if (lowcnt != LW'(RST_CYC)) lowcnt <= lowcnt + 1'b1;

  assign rst_req  = ~s2 && (lowcnt == LW'(RST_CYC - 1));
  assign width_ok = rise && (lowcnt >= LW'(2)) && (lowcnt < LW'(RST_CYC));
  assign ep_next  = fall ? '0 : inc(ep);
  assign restart  = chop_en ? fall : (width_ok && !al);
  assign filt_rst = restart;
  assign tick     = (dcnt == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ep   <= '0;
      al   <= 1'b0;
      dcnt <= '0;
    end else begin
      ep <= ep_next;
      if (fall) al <= (dcnt == '0);
      dcnt <= restart ? ep_next : inc(dcnt);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ph_flat <= '0;
    else if (ph_we && int'(ph_sel) < NCH) ph_flat[ph_sel*PHW +: PHW] <= ph_val;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [1:0] scnt;
    assign drdy[c]     = (dcnt == ph_flat[c*PHW +: PHW]);
    assign ch_valid[c] = (scnt == 2'd3);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                        scnt <= 2'd0;
      else if (restart)                  scnt <= 2'd0;
      else if (drdy[c] && scnt != 2'd3)  scnt <= scnt + 2'd1;
  end
endmodule

// File: rtl/resync_ctrl_chk.sv
module resync_ctrl_chk #(
  parameter int OSR = 16,
  parameter int NCH = 4,
  parameter int PHW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ph_we,
  input logic           tick,
  input logic           filt_rst,
  input logic           rst_req,
  input logic [NCH-1:0] drdy,
  input logic [NCH-1:0] ch_valid,
  input logic [NCH*PHW-1:0] ph_flat
);
  AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n) filt_rst |=> !filt_rst); // R2
  AST_RESET_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rst_req |=> !rst_req); // R4
  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n) (tick && !filt_rst) |=> !tick); // R6
  AST_PHASE_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (filt_rst && !ph_we) |=> $stable(ph_flat)); // R7
  AST_VALID_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) filt_rst |=> (ch_valid == '0)); // R8
  for (genvar c = 0; c < NCH; c++) begin : g_a
    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $rose(ch_valid[c]) |-> $past(drdy[c])); // R8
  end
endmodule

bind resync_ctrl resync_ctrl_chk #(.OSR(OSR), .NCH(NCH), .PHW(PHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ph_we(ph_we), .tick(tick), .filt_rst(filt_rst),
  .rst_req(rst_req), .drdy(drdy), .ch_valid(ch_valid), .ph_flat(ph_flat)
);

// File: tb/resync_ctrl_test.sv
module resync_ctrl_test;
  localparam int CLK_PER = 10;
  localparam int OSR = 16;
  localparam int NCH = 4;
  localparam int RST = 32;
  localparam int NV = 10;
  // off, width, chop, expected restarts, expected reset requests
  localparam int VEC [NV][5] = '{
    '{5, 4, 0, 1, 0},   // R2 misaligned
    '{14, 4, 0, 0, 0},  // R3 aligned
    '{5, 1, 0, 0, 0},   // R1 glitch
    '{5, 2, 0, 1, 0},   // R2 shortest legal
    '{7, 31, 0, 1, 0},  // R2 longest legal
    '{7, 32, 0, 0, 1},  // R4 threshold
    '{14, 4, 1, 1, 0},  // R5 aligned but chop
    '{3, 1, 1, 1, 0},   // R5 glitch in chop
    '{9, 40, 0, 0, 1},  // R4 long
    '{9, 40, 1, 1, 1}   // R5 long in chop
  };
  localparam int PH [NCH] = '{0, 5, 15, 3};

  logic clk = 0, rst_n = 0, sync_n = 1, chop_en = 0, ph_we = 0;
  logic [1:0] ph_sel = 0;
  logic [3:0] ph_val = 0;
  logic tick, filt_rst, rst_req;
  logic [NCH-1:0] drdy, ch_valid;

  int checks = 0, fails = 0, cyc = 0, frst_cnt = 0, rr_cnt = 0;
  int cnt [NCH];
  bit done = 0;

  resync_ctrl #(.OSR(OSR), .NCH(NCH), .RST_CYC(RST)) uut (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .chop_en(chop_en), .ph_we(ph_we),
    .ph_sel(ph_sel), .ph_val(ph_val), .tick(tick), .drdy(drdy), .ch_valid(ch_valid),
    .filt_rst(filt_rst), .rst_req(rst_req));

  always #(CLK_PER/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) cnt[c] = 0;
    forever begin
      @(negedge clk);
      #(CLK_PER/5);
      if (!rst_n) begin
        for (int c = 0; c < NCH; c++) cnt[c] = 0;
      end else begin
        if (filt_rst) frst_cnt++;
        if (rst_req) rr_cnt++;
        for (int c = 0; c < NCH; c++) begin
          chk(ch_valid[c] == (cnt[c] >= 3), "R8 settle flag", int'(ch_valid[c]), int'(cnt[c] >= 3));
          if (filt_rst) cnt[c] = 0;
          else if (drdy[c]) cnt[c]++;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    report();
  end

  task automatic wait_tick(output int t);
    do @(negedge clk); while (!tick);
    t = cyc;
  endtask

  task automatic check_offsets(input string req);
    int t;
    int first [NCH];
    for (int c = 0; c < NCH; c++) first[c] = -1;
    wait_tick(t);
    for (int k = 0; k < OSR; k++) begin
      if (k > 0) @(negedge clk);
      for (int c = 0; c < NCH; c++) if (drdy[c] && first[c] < 0) first[c] = cyc - t;
    end
    for (int c = 0; c < NCH; c++) chk(first[c] == PH[c], req, first[c], PH[c]);
  endtask

  initial begin
    int t, a, bf, br, er, r;
    repeat (3) @(negedge clk);
    chk(tick == 1, "R9 tick in reset", int'(tick), 1);
    chk(drdy == '1, "R9 drdy in reset", int'(drdy), 15);
    chk(ch_valid == '0, "R9 valid in reset", int'(ch_valid), 0);
    chk(!filt_rst && !rst_req, "R9 strobes in reset", int'({filt_rst, rst_req}), 0);
    rst_n = 1;
    for (int c = 1; c < NCH; c++) begin
      @(negedge clk);
      ph_we = 1; ph_sel = 2'(c); ph_val = 4'(PH[c]);
    end
    @(negedge clk);
    ph_we = 0;
    check_offsets("R6 strobe offset");

    for (int v = 0; v < NV; v++) begin
      wait_tick(t);
      chop_en = VEC[v][2][0];
      repeat (VEC[v][0]) @(negedge clk);
      a = cyc; bf = frst_cnt; br = rr_cnt;
      sync_n = 0;
      repeat (VEC[v][1]) @(negedge clk);
      sync_n = 1;
      repeat (8) @(negedge clk);
      chk(frst_cnt - bf == VEC[v][3], $sformatf("R2/R3/R5 restart count vec %0d", v), frst_cnt - bf, VEC[v][3]);
      chk(rr_cnt - br == VEC[v][4], $sformatf("R4 reset request count vec %0d", v), rr_cnt - br, VEC[v][4]);
      er = (VEC[v][3] != 0) ? (a + 3) % OSR : t % OSR;
      do @(negedge clk); while (!tick);
      r = cyc % OSR;
      chk(r == er, $sformatf("R1/R2/R3/R4/R5 tick phase vec %0d", v), r, er);
      chop_en = 0;
    end

    check_offsets("R7 offsets kept after resync");

    wait_tick(t);
    repeat (6) @(negedge clk);
    a = cyc;
    sync_n = 0;
    repeat (4) @(negedge clk);
    sync_n = 1;
    do @(negedge clk); while (!filt_rst);
    do @(negedge clk); while (!drdy[1]);
    chk(cyc - a < OSR, "R7 first strobe within a period", cyc - a, OSR);
    chk((cyc - a - 3) % OSR == PH[1], "R7 first strobe phase", (cyc - a - 3) % OSR, PH[1]);
    repeat (3 * OSR + 4) @(negedge clk);
    chk(ch_valid == '1, "R8 all settled", int'(ch_valid), 15);
    report();
  end
endmodule